// File: doc/BRIEF.md
# Two-Tier Reset Sequencer

This block turns an active-low power-monitor signal into the reset for a whole chip. The monitor keeps its line low until the supply rails have stayed above their limit for long enough. A second active-low input, used in simulation and test, has the same effect. While either input is low, every output of the sequencer holds its reset. Entry into reset is purely combinational from the inputs, so it works before any clock is running.

The block drives two reset tiers. The bulk tier covers most of the chip. The core tier covers the processor and every other block that can start activity on its own. Release of the bulk tier is re-timed to the system clock through a short chain of flip-flops that filters metastability. That chain forms its own reset domain. The core tier stays in reset for a parameterised number of cycles after the bulk tier releases, 3000 by default. This gives slow start-up work, such as memory repair, time to finish before the processor fetches its first instruction.

Each tier has two outputs:
- an active-low output for asynchronous reset ports;
- an active-high output for logic that uses synchronous reset.

The synchronous output enters reset one cycle after its asynchronous partner. Both outputs leave reset on the same clock edge. A done flag rises in the cycle the core tier leaves reset.

Top module: `reset_sequencer`

## Requirements
- R1: While `pmon_rst_n` or `test_rst_n` is low, `bulk_arst_n` and `core_arst_n` are low, with no clock edge needed.
- R2: After both inputs are high, `bulk_arst_n` goes high on the SYNC_STAGES-th rising clock edge that samples both inputs high.
- R3: `core_arst_n` goes high exactly HOLD_CYCLES clock edges after `bulk_arst_n` goes high, and never while `bulk_arst_n` is low.
- R4: Once released, the core tier stays released for as long as both inputs stay high, however long that is. The hold-off counter saturates at its terminal count.
- R5: Each active-high synchronous output (`bulk_srst`, `core_srst`) goes high on the first clock edge after its tier's asynchronous output goes low.
- R6: Each synchronous output goes low on the same clock edge on which its tier's asynchronous output goes high.
- R7: `boot_done` is high exactly when the core tier is out of reset, as seen on the synchronous output, and it rises on the release edge.
- R8: A trigger that arrives during the hold-off restarts the whole sequence: a new filter delay, then a new full hold-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pmon_rst_n | input | 1 | Power-monitor reset, active low |
| test_rst_n | input | 1 | Simulation/test reset, active low |
| bulk_arst_n | output | 1 | Bulk tier, for asynchronous reset ports, active low |
| bulk_srst | output | 1 | Bulk tier, for synchronous reset, active high |
| core_arst_n | output | 1 | Core tier, for asynchronous reset ports, active low |
| core_srst | output | 1 | Core tier, for synchronous reset, active high |
| boot_done | output | 1 | High once the core tier has released |

## Verification
The bench builds two copies of the block side by side.
- The first uses the defaults: a two-flop filter and a 3000-cycle hold-off. It shows the long hold-off running to terminal count, an abort partway through, and saturation over a long idle stretch.
- The second uses a three-flop filter and a one-cycle hold-off. This puts the core release on the edge right after the bulk release, so same-edge ordering and the off-by-one edges of the counter and filter come within a few cycles.

Both copies share the two trigger inputs, and a behavioural count of edges since the last trigger predicts every output at mid-cycle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  // Bits needed to hold values 0..n inclusive
  function automatic int unsigned count_bits(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((2 ** w) <= n) w++;
    return w;
  endfunction
endpackage

// File: rtl/rstseq_filter.sv
module rstseq_filter #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic filt,
  output logic filt_next
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign filt      = chain[STAGES-1];
  assign filt_next = chain[STAGES-2];

  // R1: trigger active means the filtered release is held off
  p_trigger_holds_r1: assert property (@(posedge clk) !arst_n |-> !filt);
  // R2: release of the filter only follows its predecessor stage
  p_filter_order_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(filt) |-> $past(filt_next));
endmodule

// File: rtl/rstseq_holdoff.sv
module rstseq_holdoff #(
  parameter int unsigned HOLD_CYCLES = 3000
) (
  input  logic clk,
  input  logic bulk_rel,
  output logic core_rel,
  output logic core_rel_next
);
  import rstseq_pkg::*;
  localparam int unsigned CW = count_bits(HOLD_CYCLES);
  localparam logic [CW-1:0] TERM = CW'(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge bulk_rel) begin
    if (!bulk_rel)        cnt <= '0;
    else if (cnt != TERM) cnt <= cnt + 1'b1;
  end

  assign core_rel_next = bulk_rel & (core_rel | (cnt == LAST));

  always_ff @(posedge clk or negedge bulk_rel) begin
    if (!bulk_rel) core_rel <= 1'b0;
    else           core_rel <= core_rel | (cnt == LAST);
  end

  // R4: counter saturates at its terminal count
  p_cnt_saturates_r4: assert property (@(posedge clk) disable iff (!bulk_rel)
    (cnt == TERM) |=> (cnt == TERM));
  // R3: core release only at terminal count
  p_release_at_term_r3: assert property (@(posedge clk) disable iff (!bulk_rel)
    core_rel |-> (cnt == TERM));
  // R4: once released, stays released while bulk tier is out of reset
  p_release_sticky_r4: assert property (@(posedge clk) disable iff (!bulk_rel)
    core_rel |=> core_rel);
endmodule

// File: rtl/rstseq_tier.sv
module rstseq_tier (
  input  logic clk,
  input  logic rel_now,
  input  logic rel_next,
  output logic arst_n,
  output logic srst
);
  assign arst_n = rel_now;

  always_ff @(posedge clk) srst <= ~rel_next;

  // R6: synchronous and asynchronous outputs release on the same edge
  p_same_edge_release_r6: assert property (@(posedge clk) disable iff (!rel_now)
    $rose(arst_n) |-> $fell(srst));
  // R5: synchronous reset high implies the asynchronous one is also active
  p_sync_within_async_r5: assert property (@(posedge clk) disable iff (!rel_now)
    !srst || !arst_n);
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 3000
) (
  input  logic clk,
  input  logic pmon_rst_n,
  input  logic test_rst_n,
  output logic bulk_arst_n,
  output logic bulk_srst,
  output logic core_arst_n,
  output logic core_srst,
  output logic boot_done
);
  logic trig_n;
  logic bulk_rel, bulk_rel_next;
  logic core_rel, core_rel_next;

  assign trig_n = pmon_rst_n & test_rst_n;

  rstseq_filter #(.STAGES(SYNC_STAGES)) u_filter (
    .clk(clk), .arst_n(trig_n), .filt(bulk_rel), .filt_next(bulk_rel_next)
  );

  rstseq_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_holdoff (
    .clk(clk), .bulk_rel(bulk_rel), .core_rel(core_rel), .core_rel_next(core_rel_next)
  );

  rstseq_tier u_bulk (
    .clk(clk), .rel_now(bulk_rel), .rel_next(bulk_rel_next),
    .arst_n(bulk_arst_n), .srst(bulk_srst)
  );

  rstseq_tier u_core (
    .clk(clk), .rel_now(core_rel), .rel_next(core_rel_next),
    .arst_n(core_arst_n), .srst(core_srst)
  );

  assign boot_done = ~core_srst;

  // R3: core tier never released while the bulk tier is in reset
  p_core_after_bulk_r3: assert property (@(posedge clk) disable iff (!trig_n)
    core_arst_n |-> bulk_arst_n);
  // R1: an active trigger holds both asynchronous outputs low
  p_both_held_r1: assert property (@(posedge clk)
    !trig_n |-> (!bulk_arst_n && !core_arst_n));
  // R7: done flag rises together with core release
  p_done_with_core_r7: assert property (@(posedge clk) disable iff (!trig_n)
    $rose(core_arst_n) |-> $rose(boot_done));
endmodule

// File: tb/sim_reset_sequencer.sv
module sim_reset_sequencer;
  localparam int S0 = 2, H0 = 3000;
  localparam int S1 = 3, H1 = 1;

  logic clk = 1'b0;
  logic pmon_rst_n = 1'b0;
  logic test_rst_n = 1'b1;
  logic b0a, b0s, c0a, c0s, d0;
  logic b1a, b1s, c1a, c1s, d1;

  int checks = 0;
  int errors = 0;
  int n_edges = 0;     // edges with triggers inactive since the last active one
  bit started = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  reset_sequencer u0 (
    .clk(clk), .pmon_rst_n(pmon_rst_n), .test_rst_n(test_rst_n),
    .bulk_arst_n(b0a), .bulk_srst(b0s), .core_arst_n(c0a), .core_srst(c0s), .boot_done(d0)
  );

  reset_sequencer #(.SYNC_STAGES(S1), .HOLD_CYCLES(H1)) u1 (
    .clk(clk), .pmon_rst_n(pmon_rst_n), .test_rst_n(test_rst_n),
    .bulk_arst_n(b1a), .bulk_srst(b1s), .core_arst_n(c1a), .core_srst(c1s), .boot_done(d1)
  );

  // Behavioural reference: count edges since the last trigger
  always @(posedge clk) begin
    started = 1;
    if (!(pmon_rst_n && test_rst_n)) n_edges = 0;
    else if (n_edges < 1000000) n_edges = n_edges + 1;
  end

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %b expected %b", what, $time, act, exp);
    end
  endtask

  task automatic check_inst(input int s, input int h, input logic ba, input logic bs,
                            input logic ca, input logic cs, input logic dn, input string tag);
    bit trig = !(pmon_rst_n && test_rst_n);
    bit bulk_free = n_edges >= s;
    bit core_free = n_edges >= s + h;
    chk(ba, !trig && bulk_free, {tag, " R1/R2 bulk_arst_n"});
    chk(bs, !bulk_free,         {tag, " R5/R6 bulk_srst"});
    chk(ca, !trig && core_free, {tag, " R1/R3/R4/R8 core_arst_n"});
    chk(cs, !core_free,         {tag, " R5/R6 core_srst"});
    chk(dn, core_free,          {tag, " R7 boot_done"});
  endtask

  // Compare on every clock, mid-cycle
  always @(negedge clk) begin
    if (started && !finished) begin
      check_inst(S0, H0, b0a, b0s, c0a, c0s, d0, "u0");
      check_inst(S1, H1, b1a, b1s, c1a, c1s, d1, "u1");
    end
  end

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  // Asynchronous assertion with the clock between edges (R1)
  task automatic async_probe();
    @(negedge clk); #1;
    pmon_rst_n = 1'b0;
    #1;
    chk(b0a, 1'b0, "u0 R1 async bulk before edge");
    chk(c0a, 1'b0, "u0 R1 async core before edge");
    chk(b1a, 1'b0, "u1 R1 async bulk before edge");
    chk(c1a, 1'b0, "u1 R1 async core before edge");
    chk(b0s, 1'b0, "u0 R5 sync bulk waits for edge");
  endtask

  initial begin
    step(5);
    pmon_rst_n = 1'b1;            // power good: full sequence (R2, R3)
    step(H0 + 20);
    async_probe();                // R1, R5
    step(3);
    pmon_rst_n = 1'b1;
    step(1200);                   // abort mid hold-off (R8)
    pmon_rst_n = 1'b0;
    step(2);
    pmon_rst_n = 1'b1;
    step(H0 + 10);
    test_rst_n = 1'b0;            // test reset path (R1)
    step(4);
    pmon_rst_n = 1'b0;            // overlapping triggers
    step(2);
    test_rst_n = 1'b1;
    step(2);
    pmon_rst_n = 1'b1;
    step(H0 + 4000);              // long idle: saturation (R4)
    test_rst_n = 1'b0;
    step(1);
    test_rst_n = 1'b1;
    step(10);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    finished = 1;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule